// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block watches the command bus of a four-bank double-data-rate SDRAM and reports any command that breaks bank-state or minimum-spacing rules. On every rising clock edge it decodes chip select, the three command strobes, the two bank-address bits and address bit 10. It keeps an idle or open state and a set of countdown timers for each bank, plus two shared timers. All minimum spacings are parameters in clock cycles.

A bad command produces a one-cycle violation pulse together with a 4-bit code in the cycle after the edge that sampled it. The offending command still updates the tracked state as a real device would, so a single mistake does not cause a cascade of false reports later. The block is a passive monitor that sits beside a memory controller in simulation or on silicon debug paths. It checks the data path, strobe timing, mode-register contents and the power-up sequence not at all.

Top module: `sdram_cmd_checker`

## Requirements
- R1: A command is taken only at a rising edge with `cs_n` low. Strobes {ras_n,cas_n,we_n} decode as 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 110 burst stop, 111 no-op. A cycle with `cs_n` high has no effect on state or on the outputs, but timers keep counting down.
- R2: A violation sets `viol` high for exactly the cycle after the offending edge, with `viol_code` holding its code. With no violation `viol` is low and `viol_code` is 0.
- R3: The bank is {ba[1],ba[0]}, with ba[0] the low bit. An activate opens its bank. An activate to an open bank gives code 2. A read or write to an idle bank gives code 3 and leaves all state unchanged.
- R4: A precharge with `a10` high closes every open bank. With `a10` low it closes only the addressed bank. A precharge of an idle bank changes nothing.
- R5: A read or write fewer than T_RCD cycles after the activate of its bank gives code 4.
- R6: An activate fewer than T_RP cycles after its bank was closed gives code 5. The same applies to a refresh or mode set while any bank is still within that window.
- R7: An activate fewer than T_RC cycles after the previous activate of the same bank gives code 6. A refresh or mode set while any bank is within that window also gives code 6. An activate fewer than T_RRD cycles after any activate gives code 7.
- R8: A precharge that closes a bank opened fewer than T_RAS cycles earlier gives code 8. A precharge that closes a bank read fewer than BURST_LEN/2 cycles earlier gives code 9.
- R9: A read with `a10` high closes its bank, and the bank stays closed-recovering for BURST_LEN/2+T_RP cycles. A write with `a10` high does the same for T_WR+T_RP cycles. A read or write with `a10` low leaves the row open.
- R10: Any command other than a no-op fewer than T_MRD cycles after a mode set gives code 1.
- R11: A refresh or mode set while any bank is open gives code 10.
- R12: Only one code is reported per command. Code 1 wins over all others. A bank-state error (2, 3, 10) wins over a timing error, and between timing errors the lower code wins.
- R13: An offending activate, precharge, read with `a10` or mode set still updates bank state and timers as if it were legal.
- R14: A synchronous active-high `rst` makes all banks idle, clears all timers and drives `viol` and `viol_code` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock; sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address, bit 0 least significant |
| a10 | input | 1 | Address bit 10: all-banks on precharge, auto-precharge on read/write |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 4 | Code of the reported violation, 0 when none |

## Verification
Legal sequences run at exactly the minimum gaps. They are paired with the same sequences shortened by one cycle, which separates an off-by-one timer from a correct one for each of the spacing rules. Precharge is tried with the all-banks bit set and clear, and reads and writes with and without auto-precharge. Later accesses then show which banks really closed and when the recovering bank became usable again. Commands that break two rules at once check the priority order. Deselected command patterns, accesses after an offending activate, and a reset in the middle of a run show that state changes only when it should.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_ACT,
        OP_RD,
        OP_WR,
        OP_PRE,
        OP_REF,
        OP_MRS,
        OP_BST
    } op_e;

    typedef enum logic [3:0] {
        VC_NONE      = 4'd0,
        VC_MRD       = 4'd1,
        VC_ACT_OPEN  = 4'd2,
        VC_IDLE_ACC  = 4'd3,
        VC_RCD       = 4'd4,
        VC_RP        = 4'd5,
        VC_RC        = 4'd6,
        VC_RRD       = 4'd7,
        VC_RAS       = 4'd8,
        VC_RTP       = 4'd9,
        VC_OPEN_BANK = 4'd10
    } vcode_e;

    // State of one bank as seen by the rule evaluator
    typedef struct packed {
        logic active;
        logic rcd_busy;
        logic ras_busy;
        logic rc_busy;
        logic rp_busy;
        logic rtp_busy;
    } bank_stat_t;

    function automatic op_e decode_op(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
        op_e r;
        if (cs_n) begin
            r = OP_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  r = OP_ACT;
                3'b101:  r = OP_RD;
                3'b100:  r = OP_WR;
                3'b010:  r = OP_PRE;
                3'b001:  r = OP_REF;
                3'b000:  r = OP_MRS;
                3'b110:  r = OP_BST;
                default: r = OP_NOP;
            endcase
        end
        return r;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] gap,
    output logic         busy
);
    logic [W-1:0] cnt;

    // A load of N keeps busy high for the next N-1 sampling edges
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (gap == '0) ? '0 : gap - W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_chk_pkg::*;
#(
    parameter int CW        = 5,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 7,
    parameter int T_RC      = 10,
    parameter int T_WR      = 3,
    parameter int BURST_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  op_e        op,
    input  logic       sel,
    input  logic       a10_i,
    output bank_stat_t stat
);
    localparam int HALF_BL = BURST_LEN / 2;
    localparam logic [CW-1:0] G_RCD   = CW'(T_RCD);
    localparam logic [CW-1:0] G_RAS   = CW'(T_RAS);
    localparam logic [CW-1:0] G_RC    = CW'(T_RC);
    localparam logic [CW-1:0] G_RTP   = CW'(HALF_BL);
    localparam logic [CW-1:0] G_PRE   = CW'(T_RP);
    localparam logic [CW-1:0] G_RDAP  = CW'(HALF_BL + T_RP);
    localparam logic [CW-1:0] G_WRAP  = CW'(T_WR + T_RP);

    logic          open_q;
    logic          do_act, do_rd, do_wr, close_pre, close_ap, rp_load;
    logic [CW-1:0] rp_gap;
    logic          rcd_b, ras_b, rc_b, rp_b, rtp_b;

    assign do_act    = (op == OP_ACT) && sel;
    assign do_rd     = (op == OP_RD) && sel && open_q;
    assign do_wr     = (op == OP_WR) && sel && open_q;
    assign close_pre = (op == OP_PRE) && (sel || a10_i) && open_q;
    assign close_ap  = (do_rd || do_wr) && a10_i;
    assign rp_load   = close_pre || close_ap;

    always_comb begin
        if (close_pre)  rp_gap = G_PRE;
        else if (do_rd) rp_gap = G_RDAP;
        else            rp_gap = G_WRAP;
    end

    always_ff @(posedge clk) begin
        if (rst)                       open_q <= 1'b0;
        else if (do_act)               open_q <= 1'b1;
        else if (close_pre || close_ap) open_q <= 1'b0;
    end

    sdram_gap_timer #(.W(CW)) u_rcd (.clk(clk), .rst(rst), .load(do_act),  .gap(G_RCD), .busy(rcd_b));
    sdram_gap_timer #(.W(CW)) u_ras (.clk(clk), .rst(rst), .load(do_act),  .gap(G_RAS), .busy(ras_b));
    sdram_gap_timer #(.W(CW)) u_rc  (.clk(clk), .rst(rst), .load(do_act),  .gap(G_RC),  .busy(rc_b));
    sdram_gap_timer #(.W(CW)) u_rtp (.clk(clk), .rst(rst), .load(do_rd),   .gap(G_RTP), .busy(rtp_b));
    sdram_gap_timer #(.W(CW)) u_rp  (.clk(clk), .rst(rst), .load(rp_load), .gap(rp_gap), .busy(rp_b));

    always_comb begin
        stat.active   = open_q;
        stat.rcd_busy = rcd_b;
        stat.ras_busy = ras_b;
        stat.rc_busy  = rc_b;
        stat.rp_busy  = rp_b;
        stat.rtp_busy = rtp_b;
    end
endmodule

// File: rtl/sdram_rule_eval.sv
module sdram_rule_eval
    import sdram_chk_pkg::*;
#(
    parameter int NB = 4,
    parameter int BW = 2
) (
    input  op_e                 op,
    input  logic [BW-1:0]       bank,
    input  logic                all_sel,
    input  bank_stat_t [NB-1:0] st,
    input  logic                rrd_busy,
    input  logic                mrd_busy,
    output vcode_e              code
);
    logic       any_open, any_rp, any_rc, pre_ras, pre_rtp;
    bank_stat_t tgt;

    always_comb begin
        any_open = 1'b0;
        any_rp   = 1'b0;
        any_rc   = 1'b0;
        pre_ras  = 1'b0;
        pre_rtp  = 1'b0;
        for (int i = 0; i < NB; i++) begin
            any_open = any_open | st[i].active;
            any_rp   = any_rp | st[i].rp_busy;
            any_rc   = any_rc | st[i].rc_busy;
            if (st[i].active && (all_sel || (BW'(i) == bank))) begin
                pre_ras = pre_ras | st[i].ras_busy;
                pre_rtp = pre_rtp | st[i].rtp_busy;
            end
        end
    end

    assign tgt = st[bank];

    // Priority: mode-set spacing, then bank state, then timing by code
    always_comb begin
        code = VC_NONE;
        if (mrd_busy && (op != OP_NOP)) begin
            code = VC_MRD;
        end else begin
            case (op)
                OP_ACT: begin
                    if (tgt.active)        code = VC_ACT_OPEN;
                    else if (tgt.rp_busy)  code = VC_RP;
                    else if (tgt.rc_busy)  code = VC_RC;
                    else if (rrd_busy)     code = VC_RRD;
                end
                OP_RD, OP_WR: begin
                    if (!tgt.active)       code = VC_IDLE_ACC;
                    else if (tgt.rcd_busy) code = VC_RCD;
                end
                OP_PRE: begin
                    if (pre_ras)           code = VC_RAS;
                    else if (pre_rtp)      code = VC_RTP;
                end
                OP_REF, OP_MRS: begin
                    if (any_open)          code = VC_OPEN_BANK;
                    else if (any_rp)       code = VC_RP;
                    else if (any_rc)       code = VC_RC;
                end
                default: code = VC_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdram_chk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 7,
    parameter int T_RC      = 10,
    parameter int T_RRD     = 2,
    parameter int T_WR      = 3,
    parameter int T_MRD     = 2,
    parameter int BURST_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic [1:0] ba,
    input  logic       a10,
    output logic       viol,
    output logic [3:0] viol_code
);
    localparam int BW    = $clog2(NUM_BANKS);
    localparam int MAXG  = max2(max2(max2(T_RC, T_RAS), max2(T_RCD, T_RRD)),
                                max2(max2(T_WR + T_RP, BURST_LEN / 2 + T_RP), T_MRD));
    localparam int CW    = $clog2(MAXG + 1);

    op_e                        op;
    bank_stat_t [NUM_BANKS-1:0] bank_st;
    logic                       rrd_busy, mrd_busy;
    vcode_e                     code_n;

    assign op = decode_op(cs_n, ras_n, cas_n, we_n);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdram_bank_tracker #(
            .CW(CW), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
            .T_RC(T_RC), .T_WR(T_WR), .BURST_LEN(BURST_LEN)
        ) u_trk (
            .clk(clk), .rst(rst), .op(op),
            .sel(ba[BW-1:0] == BW'(g)), .a10_i(a10),
            .stat(bank_st[g])
        );
    end

    sdram_gap_timer #(.W(CW)) u_rrd (
        .clk(clk), .rst(rst), .load(op == OP_ACT), .gap(CW'(T_RRD)), .busy(rrd_busy)
    );
    sdram_gap_timer #(.W(CW)) u_mrd (
        .clk(clk), .rst(rst), .load(op == OP_MRS), .gap(CW'(T_MRD)), .busy(mrd_busy)
    );

    sdram_rule_eval #(.NB(NUM_BANKS), .BW(BW)) u_eval (
        .op(op), .bank(ba[BW-1:0]), .all_sel(a10), .st(bank_st),
        .rrd_busy(rrd_busy), .mrd_busy(mrd_busy), .code(code_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            viol      <= 1'b0;
            viol_code <= 4'd0;
        end else begin
            viol      <= (code_n != VC_NONE);
            viol_code <= code_n;
        end
    end
endmodule

// File: rtl/sdram_cmd_checker_sva.sv
module sdram_cmd_checker_sva (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       viol,
    input logic [3:0] viol_code
);
    // R2
    code_zero_when_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !viol |-> viol_code == 4'd0);

    // R2
    code_set_when_viol_chk: assert property (@(posedge clk) disable iff (rst)
        viol |-> viol_code != 4'd0);

    // R1
    deselect_silent_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cs_n) && !$past(rst)) |-> !viol);

    // R3
    idle_access_src_chk: assert property (@(posedge clk) disable iff (rst)
        (viol && viol_code == 4'd3) |-> $past(!cs_n && ras_n && !cas_n));

    // R8
    pre_code_src_chk: assert property (@(posedge clk) disable iff (rst)
        (viol && (viol_code == 4'd8 || viol_code == 4'd9))
            |-> $past(!cs_n && !ras_n && cas_n && !we_n));

    // R11
    open_bank_src_chk: assert property (@(posedge clk) disable iff (rst)
        (viol && viol_code == 4'd10) |-> $past(!cs_n && !ras_n && !cas_n));

    // R14
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> (!viol && viol_code == 4'd0));
endmodule

bind sdram_cmd_checker sdram_cmd_checker_sva u_sva (.*);

// File: tb/sdram_cmd_checker_tb.sv
module sdram_cmd_checker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int T_RCD = 3, T_RP = 3, T_RAS = 7, T_RC = 10, T_RRD = 2;
    localparam int T_WR = 3, T_MRD = 2, BURST_LEN = 4;
    localparam int K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3;
    localparam int K_PRE = 4, K_REF = 5, K_MRS = 6, K_BST = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic       a10 = 1'b0;
    logic       viol;
    logic [3:0] viol_code;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_cmd_checker u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .viol(viol), .viol_code(viol_code)
    );

    // Reference model: timestamps of past events
    int    n = 0;
    bit    open_b[4];
    int    act_t[4];
    int    rp_rdy[4];
    int    rd_t[4];
    int    last_act, mrs_t;
    bit    pend_v = 1'b0;
    int    pend_c = 0;
    int    checks = 0, errors = 0;
    string tag = "R14";
    bit    done = 1'b0;

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            open_b[i] = 1'b0; act_t[i] = -1000; rp_rdy[i] = -1000; rd_t[i] = -1000;
        end
        last_act = -1000;
        mrs_t    = -1000;
    endtask

    task automatic compare();
        checks++;
        if (viol !== pend_v || viol_code !== 4'(pend_c)) begin
            errors++;
            $display("FAIL %s slot %0d: viol=%0b code=%0d expected viol=%0b code=%0d",
                     tag, n, viol, viol_code, pend_v, pend_c);
        end
    endtask

    task automatic model_eval(input int k, input int b, input bit ap);
        int  c;
        bit  any_open, any_rp, any_rc, p_ras, p_rtp;
        c = 0;
        any_open = 0; any_rp = 0; any_rc = 0; p_ras = 0; p_rtp = 0;
        for (int i = 0; i < 4; i++) begin
            any_open |= open_b[i];
            any_rp   |= (n < rp_rdy[i]);
            any_rc   |= (n - act_t[i] < T_RC);
            if (open_b[i] && (ap || i == b)) begin
                p_ras |= (n - act_t[i] < T_RAS);
                p_rtp |= (n - rd_t[i] < BURST_LEN / 2);
            end
        end
        if (k != K_NOP && n - mrs_t < T_MRD) c = 1;
        else if (k == K_ACT) begin
            if (open_b[b]) c = 2;
            else if (n < rp_rdy[b]) c = 5;
            else if (n - act_t[b] < T_RC) c = 6;
            else if (n - last_act < T_RRD) c = 7;
        end else if (k == K_RD || k == K_WR) begin
            if (!open_b[b]) c = 3;
            else if (n - act_t[b] < T_RCD) c = 4;
        end else if (k == K_PRE) begin
            if (p_ras) c = 8;
            else if (p_rtp) c = 9;
        end else if (k == K_REF || k == K_MRS) begin
            if (any_open) c = 10;
            else if (any_rp) c = 5;
            else if (any_rc) c = 6;
        end
        pend_v = (c != 0);
        pend_c = c;
        // state update, offending commands included
        case (k)
            K_ACT: begin open_b[b] = 1'b1; act_t[b] = n; last_act = n; end
            K_RD: if (open_b[b]) begin
                rd_t[b] = n;
                if (ap) begin open_b[b] = 1'b0; rp_rdy[b] = n + BURST_LEN / 2 + T_RP; end
            end
            K_WR: if (open_b[b] && ap) begin open_b[b] = 1'b0; rp_rdy[b] = n + T_WR + T_RP; end
            K_PRE: for (int i = 0; i < 4; i++) begin
                if (open_b[i] && (ap || i == b)) begin open_b[i] = 1'b0; rp_rdy[i] = n + T_RP; end
            end
            K_MRS: mrs_t = n;
            default: ;
        endcase
    endtask

    task automatic slot(input int k, input int b = 0, input bit ap = 1'b0, input bit desel = 1'b0);
        @(negedge clk);
        compare();
        cs_n = desel;
        case (k)
            K_ACT:   {ras_n, cas_n, we_n} = 3'b011;
            K_RD:    {ras_n, cas_n, we_n} = 3'b101;
            K_WR:    {ras_n, cas_n, we_n} = 3'b100;
            K_PRE:   {ras_n, cas_n, we_n} = 3'b010;
            K_REF:   {ras_n, cas_n, we_n} = 3'b001;
            K_MRS:   {ras_n, cas_n, we_n} = 3'b000;
            K_BST:   {ras_n, cas_n, we_n} = 3'b110;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
        ba  = 2'(b);
        a10 = ap;
        n++;
        if (rst) begin
            pend_v = 1'b0; pend_c = 0; model_reset();
        end else if (desel) begin
            model_eval(K_NOP, b, ap);
        end else begin
            model_eval(k, b, ap);
        end
    endtask

    task automatic idle(input int cnt);
        for (int i = 0; i < cnt; i++) slot(K_NOP);
    endtask

    task automatic do_reset();
        tag = "R14";
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 3; i++) slot(K_ACT, 1);
        @(negedge clk);
        compare();
        rst = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R5 legal gap, then one short
        tag = "R5";
        slot(K_ACT, 0); idle(2); slot(K_RD, 0);
        slot(K_ACT, 1); idle(1); slot(K_RD, 1);
        // R3 bank state
        tag = "R3";
        slot(K_RD, 2); slot(K_WR, 3); slot(K_ACT, 0);
        // R2 pulse ends
        tag = "R2";
        idle(2);
        // R7 activate spacing across banks
        tag = "R7";
        slot(K_ACT, 2); slot(K_ACT, 3); idle(10);
        // R8 early precharge, R7 short row cycle, R6 early activate
        tag = "R8";
        slot(K_PRE, 2); idle(2); slot(K_ACT, 2); slot(K_NOP); slot(K_PRE, 2);
        tag = "R7";
        idle(2); slot(K_ACT, 2);
        tag = "R6";
        slot(K_PRE, 2); slot(K_ACT, 2); idle(12);
        // R8 read-to-precharge
        tag = "R8";
        slot(K_RD, 0); slot(K_PRE, 0); idle(3);
        // R4 precharge all and single
        tag = "R4";
        slot(K_PRE, 0, 1'b1); idle(3); slot(K_RD, 1); slot(K_RD, 3);
        slot(K_ACT, 1); slot(K_NOP); slot(K_ACT, 3); idle(10);
        slot(K_PRE, 1); slot(K_NOP); slot(K_RD, 3); slot(K_RD, 1);
        // R9 auto-precharge recovery
        tag = "R9";
        slot(K_WR, 3, 1'b1); idle(4); slot(K_ACT, 3);
        // R13 offending activate still opened the bank
        tag = "R13";
        idle(2); slot(K_RD, 3); idle(10);
        tag = "R9";
        slot(K_WR, 3, 1'b1); idle(5); slot(K_ACT, 3); idle(2);
        slot(K_RD, 3, 1'b1); idle(3); slot(K_ACT, 3); idle(4); slot(K_RD, 3);
        // R11 refresh / mode set with open bank
        tag = "R11";
        idle(3); slot(K_REF); slot(K_MRS);
        // R10 mode-set spacing
        tag = "R10";
        slot(K_BST); idle(2);
        // R12 priority: mode-set spacing over open-bank activate
        tag = "R12";
        slot(K_MRS); slot(K_ACT, 3); idle(3);
        tag = "R6";
        slot(K_PRE, 0, 1'b1); slot(K_REF); idle(12); slot(K_REF);
        tag = "R10";
        slot(K_MRS); slot(K_NOP); slot(K_ACT, 0); idle(3);
        // R1 deselected cycles ignored
        tag = "R1";
        slot(K_ACT, 1, 1'b0, 1'b1); idle(3); slot(K_RD, 1);
        slot(K_MRS); slot(K_RD, 1, 1'b0, 1'b1); slot(K_NOP);
        // R14 reset in mid-run
        slot(K_ACT, 2); idle(4);
        do_reset();
        tag = "R14";
        slot(K_RD, 0); slot(K_RD, 2); idle(2);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule